// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock recovery loop has reached the right frequency. It runs in the reference clock domain, nominally 14.140 MHz. Each reference cycle it adds up the divided-VCO edges that a prescaler reports for that cycle. Every `WIN` reference cycles it compares the total with an expected count, `EXP_CNT`. The external feedback divider for the active rate, a ratio of 152, 160 or 208 together with a rate divider of 2, 4, 6, 8, 12 or 16, is chosen so that a correct VCO frequency gives the same expected count at every rate.

The thresholds for entering and leaving lock differ. To gain lock, the count must fall within a narrow band of about 1% in two windows in a row. Once locked, the block drops lock only when a window's error is larger than a wide band of about 2%. While unlocked, the loop-mode output selects frequency acquisition; while locked, it selects phase acquisition. A change of the rate select clears lock at once and starts a fresh measurement.

Top module: `freq_lock_detect`

## Requirements
- R1: During and after reset, `locked` and `pa_mode` are 0 until the lock rules below raise them.
- R2: Lock is gained only after two consecutive windows whose edge count is within ±`TOL_IN` (10) of `EXP_CNT` (1024). `locked` rises at the end of the second such window.
- R3: An out-of-tolerance window restarts the run of good windows. A good window, then a bad one, then a good one does not gain lock.
- R4: The narrow band includes its limits. Counts of 1014 and 1034 qualify, and 1013 and 1035 do not.
- R5: While locked, a window whose count is within ±`TOL_OUT` (20) keeps lock. This includes 1004, 1044 and counts between 10 and 20 away from 1024.
- R6: While locked, a window whose count is more than 20 away from 1024 (1003 or below, 1045 or above) clears `locked` at the end of that window.
- R7: When `rate_sel` differs from its value in the previous cycle, `locked` is 0 from the next cycle. The cycle in which the change is seen is discarded, and a new window starts on the cycle after it.
- R8: `pa_mode` is 1 (phase acquisition) exactly when `locked` is 1, and 0 (frequency acquisition) otherwise.
- R9: `locked` changes only at the end of a window or on a rate change, never in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | RATE_W | Active rate code |
| vco_edges | input | EDGE_W | Divided-VCO edges seen during this reference cycle |
| locked | output | 1 | Lock flag, active high |
| pa_mode | output | 1 | 1 = phase acquisition, 0 = frequency acquisition |

## Verification
The bench drives windows whose counts sit exactly on both edges of the narrow band and both edges of the wide band. A design with an off-by-one limit would gain lock at 1013, or fail to gain it at 1034. It also checks that a count between 1% and 2% off keeps an existing lock but cannot create one. A design with a single threshold would drop lock at 1044 or gain lock at 1040. A good, bad, good sequence catches a run counter that does not restart. A rate change while locked catches a design that keeps its stale lock. A bad window probed halfway through catches a design that drops lock before the window ends.

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int WIN     = 1024,
  parameter int EXP_CNT = 1024,
  parameter int TOL_IN  = 10,
  parameter int TOL_OUT = 20,
  parameter int GOOD_N  = 2,
  parameter int RATE_W  = 3,
  parameter int EDGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [EDGE_W-1:0] vco_edges,
  output logic              locked,
  output logic              pa_mode
);
  localparam int WCNT_W = $clog2(WIN);
  localparam int ACC_W  = $clog2(WIN * ((1 << EDGE_W) - 1) + 1);
  localparam int GOOD_W = $clog2(GOOD_N + 1);

  logic [WCNT_W-1:0] wcnt;
  logic [ACC_W-1:0]  acc;
  logic [GOOD_W-1:0] good;
  logic [RATE_W-1:0] rate_q;
  logic              lock_q;

  wire              last     = wcnt == WCNT_W'(WIN - 1);
  wire              rate_chg = rate_sel != rate_q;
  wire [ACC_W-1:0]  sum      = acc + ACC_W'(vco_edges);
  wire              in_tight = (sum >= ACC_W'(EXP_CNT - TOL_IN))  && (sum <= ACC_W'(EXP_CNT + TOL_IN));
  wire              in_wide  = (sum >= ACC_W'(EXP_CNT - TOL_OUT)) && (sum <= ACC_W'(EXP_CNT + TOL_OUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt   <= '0;
      acc    <= '0;
      good   <= '0;
      rate_q <= '0;
      lock_q <= 1'b0;
    end else begin
      rate_q <= rate_sel;
      if (rate_chg) begin
        wcnt   <= '0;
        acc    <= '0;
        good   <= '0;
        lock_q <= 1'b0;
      end else if (last) begin
        wcnt <= '0;
        acc  <= '0;
        if (lock_q) begin
          good <= '0;
          if (!in_wide) lock_q <= 1'b0;
        end else if (in_tight) begin
          if (good == GOOD_W'(GOOD_N - 1)) begin
            lock_q <= 1'b1;
            good   <= '0;
          end else begin
            good <= good + GOOD_W'(1);
          end
        end else begin
          good <= '0;
        end
      end else begin
        wcnt <= wcnt + WCNT_W'(1);
        acc  <= sum;
      end
    end
  end

  assign locked  = lock_q;
  assign pa_mode = lock_q;
endmodule

// File: rtl/freq_lock_detect_chk.sv
module freq_lock_detect_chk #(
  parameter int WIN    = 1024,
  parameter int GOOD_N = 2,
  parameter int RATE_W = 3,
  parameter int WCNT_W = 10,
  parameter int GOOD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [RATE_W-1:0] rate_sel,
  input logic [RATE_W-1:0] rate_q,
  input logic [WCNT_W-1:0] wcnt,
  input logic [GOOD_W-1:0] good,
  input logic              locked,
  input logic              pa_mode
);
  a_r2_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(wcnt) == WCNT_W'(WIN - 1)));

  a_r2_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(good) == GOOD_W'(GOOD_N - 1)));

  a_r7_rate_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != rate_q) |=> !locked);

  a_r9_stable_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != WCNT_W'(WIN - 1) && rate_sel == rate_q) |=> $stable(locked));

  a_r8_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $fell(pa_mode));
endmodule

bind freq_lock_detect freq_lock_detect_chk #(
  .WIN(WIN), .GOOD_N(GOOD_N), .RATE_W(RATE_W), .WCNT_W(WCNT_W), .GOOD_W(GOOD_W)
) chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rate_q(rate_q),
  .wcnt(wcnt), .good(good), .locked(locked), .pa_mode(pa_mode)
);

// File: tb/freq_lock_detect_test.sv
module freq_lock_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic [1:0] vco_edges = 2'd0;
  logic       locked, pa_mode;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  freq_lock_detect uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .vco_edges(vco_edges),
    .locked(locked), .pa_mode(pa_mode)
  );

  localparam int NV = 16;
  localparam int VCNT [NV] = '{
    1024, // R3 first good window
    1050, // R3 bad window restarts run
    1024, // R3
    1024, // R2 second consecutive good window
    1044, // R5 upper wide limit
    1004, // R5 lower wide limit
    1045, // R6 just above wide limit
    1014, // R4 lower tight limit
    1034, // R4 upper tight limit
    1003, // R6 just below wide limit
    1013, // R4 below tight band
    1024, // R4
    1035, // R4 above tight band
    1024, // R2
    1024, // R2
    1040  // R5 between 1% and 2% keeps lock
  };
  localparam bit VLK [NV] = '{0,0,0,1,1,1,0,0,1,0,0,0,0,0,1,1};
  localparam int VREQ [NV] = '{3,3,3,2,5,5,6,4,4,6,4,4,4,2,2,5};

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Call at a negedge; returns at the negedge after the window's last edge.
  task automatic run_window(input int cnt, input bit mid_chk, input logic mid_exp);
    for (int i = 0; i < 1024; i++) begin
      if (cnt >= 1024) vco_edges = (i < cnt - 1024) ? 2'd2 : 2'd1;
      else             vco_edges = (i < cnt) ? 2'd1 : 2'd0;
      @(negedge clk);
      if (mid_chk && i == 511) check("R9", locked, mid_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", locked, 1'b0);
    check("R1", pa_mode, 1'b0);
    rst_n = 1'b1;
    check("R1", locked, 1'b0);

    for (int v = 0; v < NV; v++) begin
      run_window(VCNT[v], 1'b0, 1'b0);
      check($sformatf("R%0d", VREQ[v]), locked, VLK[v]);
      check("R8", pa_mode, VLK[v]);
    end

    // R9: bad window while locked keeps lock at mid-window, drops at end (R6)
    run_window(1100, 1'b1, 1'b1);
    check("R6", locked, 1'b0);
    check("R8", pa_mode, 1'b0);

    // R7: relock, then rate change clears lock immediately
    run_window(1024, 1'b0, 1'b0);
    run_window(1024, 1'b0, 1'b0);
    check("R2", locked, 1'b1);
    rate_sel = 3'd4;
    vco_edges = 2'd1;
    @(negedge clk);
    check("R7", locked, 1'b0);
    check("R7", pa_mode, 1'b0);
    run_window(1024, 1'b0, 1'b0);
    check("R7", locked, 1'b0);
    run_window(1024, 1'b0, 1'b0);
    check("R7", locked, 1'b1);

    // R1: reset while locked
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", locked, 1'b0);
    check("R1", pa_mode, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule